// File: doc/BRIEF.md
# Variable-Depth Receive Message FIFO Controller

This block keeps the bookkeeping for a receive queue that is built from eight message-buffer slots. The first two slots are always receive slots. The six that follow can each be configured as receive or transmit. The queue is contiguous from slot 0. It ends just before the first configurable slot marked as transmit, so its depth lies between 2 and 8 and is set at run time. The payload storage sits outside the block. The block only says which slot to write and tracks which slots hold unread data.

Each accepted message is written to the slot at the write pointer. The block then sets that slot's full flag and moves the write pointer on. The host reads the slot at the read pointer. When it is done, the host clears that slot's full flag, and the block moves the read pointer on. Both pointers wrap at the current depth.

The block gives an empty indication, an interrupt code, and a watermark interrupt. The watermark threshold is one free slot or four free slots. A message that arrives while the queue is full is dropped, and a sticky overflow flag is set. A flush, or a reset, clears the queue and reloads the depth from the transmit configuration.

Top module: `rxq_ctrl`

## Requirements
- R1: The depth is 2 + k, where k is the index of the lowest set bit of `prog_is_tx`. If no bit is set, the depth is 8. The depth is loaded at reset and at flush.
- R2: On `msg_accept` with free space, `wr_en` is 1 in the same cycle and `wr_slot` equals the write pointer. After that clock edge, `full_flags[wr_slot]` is 1. Slot i is `full_flags` bit i: slots 0 and 1 are the fixed receive slots, and slots 2 to 7 are configurable slots 0 to 5.
- R3: The write pointer and the read pointer each step from depth-1 back to 0.
- R4: A `host_clr` naming the slot at `rd_ptr` while that slot is full clears its flag and advances `rd_ptr` one cycle later. A `host_clr` naming any other slot leaves the flags and `rd_ptr` unchanged.
- R5: `fifo_empty` is 1 exactly when the full flag of the slot at `rd_ptr` is 0. After reset, `rd_ptr` is 0, all flags are 0 and the queue is empty.
- R6: `int_code` is 5'b10000 while the queue holds at least one message, and 5'b00000 when it is empty.
- R7: Let free = depth minus the number of full slots. `wm_irq` is 1 when the queue is not empty and free <= T. T is 1 when `wm_sel`=0 and 4 when `wm_sel`=1.
- R8: A `msg_accept` while every slot of the current depth is full gives `wr_en`=0 and leaves the flags unchanged. It sets `overflow`, which stays 1 until the next reset or flush.
- R9: A change to `prog_is_tx` does not change `depth` until a flush. A flush clears all flags, both pointers and `overflow`. Any accept or clear in the same cycle as a flush is ignored.
- R10: An accept and a valid clear in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_is_tx | input | 6 | Per configurable slot: 1 means the slot is configured as transmit |
| wm_sel | input | 1 | Watermark threshold select: 0 means 1 free slot, 1 means 4 free slots |
| flush | input | 1 | Clears the queue and reloads the depth |
| msg_accept | input | 1 | One-cycle strobe for an accepted incoming message |
| host_clr | input | 1 | Host request to clear a slot's full flag |
| host_clr_slot | input | 3 | Slot named by the host clear |
| wr_en | output | 1 | Write the payload into `wr_slot` this cycle |
| wr_slot | output | 3 | Current write pointer |
| full_flags | output | 8 | Per-slot full flags |
| rd_ptr | output | 3 | Oldest unread slot |
| fifo_empty | output | 1 | Queue is empty |
| depth | output | 4 | Current depth |
| int_code | output | 5 | Receive interrupt code |
| wm_irq | output | 1 | Watermark interrupt |
| overflow | output | 1 | Sticky flag for a dropped message |

## Verification
A write pointer that drifts from the read pointer shows up at once on `wr_slot`. It also shows one edge later as a full flag set in the wrong slot, or as a `fifo_empty` that no longer follows the flag at `rd_ptr`. A wrong wrap point shows after depth writes: the next `wr_slot` or `rd_ptr` is not 0.

A wrong depth latch only shows once the queue is filled, when `wr_en` fails to drop or drops early. A miscounted fill level shows as `wm_irq` changing one write too early or too late.

// File: rtl/rxq_pkg.sv
// Package rxq_pkg: constants and types shared by the receive queue controller.
package rxq_pkg;
    localparam logic [4:0] ICODE_NONE    = 5'b00000;
    localparam logic [4:0] ICODE_FIFO_RX = 5'b10000;

    typedef enum logic {
        WM_ONE_FREE  = 1'b0,
        WM_FOUR_FREE = 1'b1
    } wm_sel_e;
endpackage

// File: rtl/rxq_depth.sv
// rxq_depth: turns the per-slot transmit configuration into a queue depth.
// The depth ends just before the lowest configurable slot marked as transmit.
// If no slot is marked, every slot is used.
// Assumes: the fixed receive slots come first, then the configurable slots in index order.
module rxq_depth #(
    parameter int NUM_DED  = 2,
    parameter int NUM_PROG = 6,
    parameter int DW       = 4
) (
    input  logic [NUM_PROG-1:0] prog_is_tx,
    output logic [DW-1:0]       depth
);
    // Priority scan: the lowest transmit slot wins.
    always_comb begin
        depth = DW'(NUM_DED + NUM_PROG);
        for (int i = NUM_PROG - 1; i >= 0; i--) begin
            if (prog_is_tx[i]) depth = DW'(NUM_DED + i);
        end
    end
endmodule

// File: rtl/rxq_ptr.sv
// rxq_ptr: a slot pointer that steps by one and wraps from depth-1 back to 0.
// Assumes: depth >= 1, and depth changes only in a cycle where clr is high.
module rxq_ptr #(
    parameter int PW = 3,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [DW-1:0] depth,
    output logic [PW-1:0] ptr
);
    logic [DW-1:0] last;

    // Index of the last slot in the current depth.
    always_comb last = depth - DW'(1);

    // Pointer register: reset and clr go to 0, step advances with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      ptr <= '0;
        else if (step) begin
            if (DW'(ptr) == last) ptr <= '0;
            else                  ptr <= ptr + PW'(1);
        end
    end

    // R3: the pointer never leaves the current depth.
    a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (DW'(ptr) < depth));
endmodule

// File: rtl/rxq_flags.sv
// rxq_flags: the per-slot full flags. A flag is set when a message is stored
// and cleared when the host releases the slot.
// Assumes: set and clear never name the same slot in the same cycle.
module rxq_flags #(
    parameter int SLOTS = 8,
    parameter int PW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_en,
    input  logic [PW-1:0]    set_idx,
    input  logic             clr_en,
    input  logic [PW-1:0]    clr_idx,
    output logic [SLOTS-1:0] flags
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // One flag per slot: set on store, clear on host release.
        always_ff @(posedge clk) begin
            if (!rst_n || flush)                            flags[s] <= 1'b0;
            else if (set_en && set_idx == PW'(s))           flags[s] <= 1'b1;
            else if (clr_en && clr_idx == PW'(s))           flags[s] <= 1'b0;
        end
    end

    // R10: a store and a release never name the same slot.
    a_r10_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en && set_idx == clr_idx));
endmodule

// File: rtl/rxq_ctrl.sv
// rxq_ctrl: the top of the receive queue controller. It selects the slot for each
// accepted message, tracks the full flags, handles host releases, and drives the
// empty, interrupt-code, watermark and overflow outputs.
// Assumes: the payload is written outside the block when wr_en is high, and the
// transmit configuration is applied by a flush or a reset.
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int NUM_DED  = 2,
    parameter int NUM_PROG = 6,
    parameter int WM_LO    = 1,
    parameter int WM_HI    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PROG-1:0]               prog_is_tx,
    input  logic                              wm_sel,
    input  logic                              flush,
    input  logic                              msg_accept,
    input  logic                              host_clr,
    input  logic [$clog2(NUM_DED+NUM_PROG)-1:0] host_clr_slot,
    output logic                              wr_en,
    output logic [$clog2(NUM_DED+NUM_PROG)-1:0] wr_slot,
    output logic [NUM_DED+NUM_PROG-1:0]       full_flags,
    output logic [$clog2(NUM_DED+NUM_PROG)-1:0] rd_ptr,
    output logic                              fifo_empty,
    output logic [$clog2(NUM_DED+NUM_PROG+1)-1:0] depth,
    output logic [4:0]                        int_code,
    output logic                              wm_irq,
    output logic                              overflow
);
    localparam int SLOTS = NUM_DED + NUM_PROG;
    localparam int PW    = $clog2(SLOTS);
    localparam int DW    = $clog2(SLOTS + 1);

    logic [DW-1:0] depth_cfg;
    logic [DW-1:0] fill;
    logic [DW-1:0] free_cnt;
    logic [DW-1:0] thr;
    logic          clr_ok;
    logic          drop;

    rxq_depth #(.NUM_DED(NUM_DED), .NUM_PROG(NUM_PROG), .DW(DW)) u_depth (
        .prog_is_tx (prog_is_tx),
        .depth      (depth_cfg)
    );

    // Depth register: loaded only at reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) depth <= depth_cfg;
    end

    // Accept and release qualification. A flush overrides both.
    always_comb begin
        wr_en  = msg_accept && !flush && !full_flags[wr_slot];
        drop   = msg_accept && !flush &&  full_flags[wr_slot];
        clr_ok = host_clr && !flush && (host_clr_slot == rd_ptr) && full_flags[rd_ptr];
    end

    rxq_ptr #(.PW(PW), .DW(DW)) u_wptr (
        .clk (clk), .rst_n (rst_n), .clr (flush), .step (wr_en),
        .depth (depth), .ptr (wr_slot)
    );

    rxq_ptr #(.PW(PW), .DW(DW)) u_rptr (
        .clk (clk), .rst_n (rst_n), .clr (flush), .step (clr_ok),
        .depth (depth), .ptr (rd_ptr)
    );

    rxq_flags #(.SLOTS(SLOTS), .PW(PW)) u_flags (
        .clk (clk), .rst_n (rst_n), .flush (flush),
        .set_en (wr_en), .set_idx (wr_slot),
        .clr_en (clr_ok), .clr_idx (rd_ptr),
        .flags (full_flags)
    );

    // Sticky overflow: set on a dropped message, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) overflow <= 1'b0;
        else if (drop)       overflow <= 1'b1;
    end

    // Fill level, free count and watermark threshold.
    always_comb begin
        fill = '0;
        for (int s = 0; s < SLOTS; s++) fill = fill + DW'(full_flags[s]);
        free_cnt = depth - fill;
        thr      = (wm_sel == WM_FOUR_FREE) ? DW'(WM_HI) : DW'(WM_LO);
    end

    // Status outputs derived from the flag at the read pointer and the free count.
    always_comb begin
        fifo_empty = !full_flags[rd_ptr];
        int_code   = fifo_empty ? ICODE_NONE : ICODE_FIFO_RX;
        wm_irq     = !fifo_empty && (free_cnt <= thr);
    end

    // R2: a store leaves its slot marked full.
    a_r2_store_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full_flags[$past(wr_slot)]);

    // R8: no write is issued when every slot of the current depth is full.
    a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == depth) |-> !wr_en);

    // R8: the overflow flag holds until a flush.
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    // R9: the depth stays fixed without a flush.
    a_r9_depth_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> $stable(depth));

    // R6: a receive code is only shown while a message is present.
    a_r6_code_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        (int_code != ICODE_NONE) |-> (fill != '0));
endmodule

// File: tb/rxq_ctrl_test.sv
// Bench for rxq_ctrl: a table-driven run through one fill/drain cycle at depth 5,
// followed by directed tests for reset, depth selection, the watermark, overflow and flush.
module rxq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] prog_is_tx;
    logic       wm_sel, flush, msg_accept, host_clr;
    logic [2:0] host_clr_slot;
    logic       wr_en;
    logic [2:0] wr_slot;
    logic [7:0] full_flags;
    logic [2:0] rd_ptr;
    logic       fifo_empty;
    logic [3:0] depth;
    logic [4:0] int_code;
    logic       wm_irq, overflow;

    int checks = 0;
    int failures = 0;

    // Vector fields: {acc, clr, clr_slot[3], exp_wr_en, exp_wr_slot[3], exp_rd[3], exp_flags[8], exp_ovf}
    localparam logic [20:0] VEC [NV] = '{
        {1'b1,1'b0,3'd0, 1'b1,3'd0, 3'd0, 8'h01, 1'b0},
        {1'b1,1'b0,3'd0, 1'b1,3'd1, 3'd0, 8'h03, 1'b0},
        {1'b1,1'b0,3'd0, 1'b1,3'd2, 3'd0, 8'h07, 1'b0},
        {1'b0,1'b1,3'd0, 1'b0,3'd3, 3'd1, 8'h06, 1'b0},
        {1'b1,1'b1,3'd1, 1'b1,3'd3, 3'd2, 8'h0C, 1'b0},
        {1'b1,1'b0,3'd0, 1'b1,3'd4, 3'd2, 8'h1C, 1'b0},
        {1'b1,1'b0,3'd0, 1'b1,3'd0, 3'd2, 8'h1D, 1'b0},
        {1'b1,1'b0,3'd0, 1'b1,3'd1, 3'd2, 8'h1F, 1'b0},
        {1'b1,1'b0,3'd0, 1'b0,3'd2, 3'd2, 8'h1F, 1'b1},
        {1'b0,1'b1,3'd4, 1'b0,3'd2, 3'd2, 8'h1F, 1'b1},
        {1'b0,1'b1,3'd2, 1'b0,3'd2, 3'd3, 8'h1B, 1'b1},
        {1'b0,1'b1,3'd3, 1'b0,3'd2, 3'd4, 8'h13, 1'b1},
        {1'b0,1'b1,3'd4, 1'b0,3'd2, 3'd0, 8'h03, 1'b1},
        {1'b0,1'b1,3'd0, 1'b0,3'd2, 3'd1, 8'h02, 1'b1},
        {1'b0,1'b1,3'd1, 1'b0,3'd2, 3'd2, 8'h00, 1'b1}
    };

    rxq_ctrl uut (
        .clk (clk), .rst_n (rst_n), .prog_is_tx (prog_is_tx), .wm_sel (wm_sel),
        .flush (flush), .msg_accept (msg_accept), .host_clr (host_clr),
        .host_clr_slot (host_clr_slot), .wr_en (wr_en), .wr_slot (wr_slot),
        .full_flags (full_flags), .rd_ptr (rd_ptr), .fifo_empty (fifo_empty),
        .depth (depth), .int_code (int_code), .wm_irq (wm_irq), .overflow (overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_flush(input logic [5:0] cfg);
        @(negedge clk); prog_is_tx = cfg; flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic accept_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); msg_accept = 1'b1;
        end
        @(negedge clk); msg_accept = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; prog_is_tx = 6'b001000; wm_sel = 1'b0; flush = 1'b0;
        msg_accept = 1'b0; host_clr = 1'b0; host_clr_slot = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 and R1: state after reset
        check("R5", "rd_ptr after reset", rd_ptr, 0);
        check("R5", "flags after reset", full_flags, 0);
        check("R5", "empty after reset", fifo_empty, 1);
        check("R6", "code when empty", int_code, 0);
        check("R1", "depth with configurable slot 3 as transmit", depth, 5);
        check("R8", "overflow after reset", overflow, 0);

        // Table walk: fill, wrap, overflow, ignored clear, drain (R2 R3 R4 R5 R6 R8 R10)
        for (int i = 0; i < NV; i++) begin
            msg_accept    = VEC[i][20];
            host_clr      = VEC[i][19];
            host_clr_slot = VEC[i][18:16];
            #1;
            check("R2", $sformatf("v%0d wr_en", i), wr_en, VEC[i][15]);
            check("R3", $sformatf("v%0d wr_slot", i), wr_slot, VEC[i][14:12]);
            @(negedge clk);
            check("R4", $sformatf("v%0d rd_ptr", i), rd_ptr, VEC[i][11:9]);
            check("R10", $sformatf("v%0d flags", i), full_flags, VEC[i][8:1]);
            check("R8", $sformatf("v%0d overflow", i), overflow, VEC[i][0]);
            check("R5", $sformatf("v%0d empty", i), fifo_empty,
                  (VEC[i][1 + VEC[i][11:9]] == 1'b0) ? 1 : 0);
            check("R6", $sformatf("v%0d int_code", i), int_code,
                  (VEC[i][1 + VEC[i][11:9]] == 1'b0) ? 0 : 16);
        end
        msg_accept = 1'b0; host_clr = 1'b0;

        // R1: depth selection
        do_flush(6'b000000); check("R1", "depth none transmit", depth, 8);
        do_flush(6'b000001); check("R1", "depth slot 0 transmit", depth, 2);
        do_flush(6'b101000); check("R1", "depth first transmit at 3", depth, 5);
        check("R9", "overflow cleared by flush", overflow, 0);

        // R9: a configuration change without a flush is held off
        @(negedge clk); prog_is_tx = 6'b000001;
        @(negedge clk); @(negedge clk);
        check("R9", "depth unchanged without flush", depth, 5);

        // R7: watermark at depth 8
        do_flush(6'b000000);
        wm_sel = 1'b1;
        accept_n(3);
        check("R7", "wm four-free with 5 free", wm_irq, 0);
        accept_n(1);
        check("R7", "wm four-free with 4 free", wm_irq, 1);
        wm_sel = 1'b0; #1;
        check("R7", "wm one-free with 4 free", wm_irq, 0);
        accept_n(3);
        check("R7", "wm one-free with 1 free", wm_irq, 1);
        accept_n(1);
        check("R2", "full at depth 8", full_flags, 8'hFF);
        check("R3", "write pointer wrapped at depth 8", wr_slot, 0);
        @(negedge clk); msg_accept = 1'b1; #1;
        check("R8", "no write when full", wr_en, 0);
        @(negedge clk); msg_accept = 1'b0;
        check("R8", "overflow set", overflow, 1);
        check("R8", "flags unchanged on drop", full_flags, 8'hFF);

        // R9: a flush ignores a simultaneous accept and clears everything
        @(negedge clk); flush = 1'b1; msg_accept = 1'b1; prog_is_tx = 6'b000001;
        @(negedge clk); flush = 1'b0; msg_accept = 1'b0;
        check("R9", "flags cleared by flush", full_flags, 0);
        check("R9", "overflow cleared by flush", overflow, 0);
        check("R9", "depth reloaded by flush", depth, 2);

        // R7: an empty queue gives no watermark, even when free <= threshold
        wm_sel = 1'b1; #1;
        check("R7", "wm quiet when empty", wm_irq, 0);
        accept_n(1);
        check("R7", "wm after one message at depth 2", wm_irq, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule